// File: doc/BRIEF.md
# Strobed Synchronous Serial Slave

This block receives two-byte frames over a three-wire serial link made of a frame strobe, a host-driven shift clock and one data line. A frame is open only while the strobe is low. The first byte is a header: a run of sync bits, a direction bit, a register-select bit and a closing bit. The second byte either carries an instruction or data byte from the host, or carries a read value back to the host. A write frame ends in a one-cycle write pulse with the register select and the received byte. A read frame requests a byte from the controller as soon as the header is complete. That byte is then shifted out on the falling clock edges of the second byte.

The block runs on the system clock and oversamples the three pins through synchronizer chains. The shift clock's high and low phases are therefore expected to last many system clocks. The data line is split into a receive input, a transmit output and an output enable. The bidirectional pad belongs to the level above.

Top module: `strobed_serial_slave`

## Requirements
- R1: After a synchronous active-low reset, sdo_oe, sdo_out, wr_pulse, rd_req, wr_rs, rd_rs and wr_data are all zero.
- R2: A frame is open only while stb_in is low. stb_in seen high at any point returns the block to waiting for a header bit, discards a partial frame without any pulse, and drives sdo_oe and sdo_out to zero. The next low level opens a fresh frame.
- R3: Header bits 0 to 4, in transmission order, must all be 1, and header bit 7 must be 0. On any mismatch the rest of the frame is ignored until stb_in goes high: no wr_pulse, no rd_req, and sdo_oe stays zero.
- R4: Every bit is sent least-significant first and is sampled on a rising edge of sck_in. Header bit 5 selects the direction (0 = host writes the second byte, 1 = host reads it). Header bit 6 is the register select (0 = instruction, 1 = data).
- R5: In a write frame, the eighth rising edge of the second byte produces exactly one wr_pulse cycle. wr_data then holds the eight received bits (first bit in bit 0), and wr_rs holds the register select. The pulse rises SYNC_STAGES clock edges after the first clock edge that samples that sck_in rise.
- R6: In a read frame with a valid header, rd_req is high for exactly one cycle after the last header bit, and rd_rs carries the register select. rd_data is captured on the clock edge at which rd_req is high.
- R7: In a read frame, bit 0 of the captured byte is driven on the first sck_in fall after the header, and each later fall drives the next bit, up to eight bits. sdo_oe rises with the first driven bit. A change on rd_data after the capture does not alter the shifted bits.
- R8: A write frame never raises sdo_oe.
- R9: Clock bits beyond the second byte are ignored: a write frame gives no second wr_pulse, and sdo_out keeps the last driven bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_in | input | 1 | Frame strobe pin, low while a frame is open |
| sck_in | input | 1 | Shift clock pin from the host |
| sdi_in | input | 1 | Receive side of the data pad |
| sdo_out | output | 1 | Transmit side of the data pad |
| sdo_oe | output | 1 | Output enable for the data pad |
| wr_pulse | output | 1 | One-cycle write strobe to the controller |
| wr_rs | output | 1 | Register select of the last write |
| wr_data | output | WORD_BITS | Byte of the last write |
| rd_req | output | 1 | One-cycle read request to the controller |
| rd_rs | output | 1 | Register select of the last read request |
| rd_data | input | WORD_BITS | Read byte from the controller, valid while rd_req is high |

## Verification
The bench builds the block with SYNC_STAGES = 3 rather than the default 2. Its reference model takes the synchronizer depth as a parameter, so this checks that the pin-to-pulse latency follows the parameter instead of a fixed count. SYNC_BITS and WORD_BITS keep their defaults of 5 and 8, which match the header layout the host drives. The shift-clock phases are 40 system clocks long, so synchronizer latency never overlaps two link edges. This lets the edge-exact alignment of wr_pulse, rd_req and each driven read bit be compared on every clock.

// File: rtl/sss_pkg.sv
// Package: shared types for the strobed serial slave.
// Assumes: nothing beyond IEEE 1800-2017.
package sss_pkg;

    // Frame sequencer states: header reception, write body, read body, idle-until-strobe.
    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_WBODY = 2'd1,
        ST_RBODY = 2'd2,
        ST_HOLD  = 2'd3
    } frame_st_t;

endpackage

// File: rtl/sss_sync.sv
// Module: sss_sync
// Brings WIDTH asynchronous pins into the clk domain through STAGES flops each.
// Assumes: STAGES >= 2; RESET_VAL gives each bit's reset level.
module sss_sync #(
    parameter int              STAGES    = 2,
    parameter int              WIDTH     = 3,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        // Shift one pin through its flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], din[b]};
        end

        assign dout[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/sss_frame.sv
// Module: sss_frame
// Sequences one frame: checks the header, records direction and register
// select, collects a write byte and raises the write pulse or the read request.
// Assumes: inputs are already synchronized; sck phases span several clocks.
module sss_frame
    import sss_pkg::*;
#(
    parameter int SYNC_BITS = 5,
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb_s,
    input  logic                 sck_s,
    input  logic                 sdi_s,
    output logic                 wr_pulse,
    output logic                 wr_rs,
    output logic [WORD_BITS-1:0] wr_data,
    output logic                 rd_req,
    output logic                 rd_rs,
    output logic                 rd_phase,
    output logic                 sck_fall
);

    localparam int HEAD_BITS = SYNC_BITS + 3;
    localparam int MAX_BITS  = (HEAD_BITS > WORD_BITS) ? HEAD_BITS : WORD_BITS;
    localparam int CNT_W     = $clog2(MAX_BITS);
    localparam logic [CNT_W-1:0] POS_DIR  = CNT_W'(SYNC_BITS);
    localparam logic [CNT_W-1:0] POS_SEL  = CNT_W'(SYNC_BITS + 1);
    localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(SYNC_BITS + 2);
    localparam logic [CNT_W-1:0] POS_SYNC = CNT_W'(SYNC_BITS);
    localparam logic [CNT_W-1:0] BODY_END = CNT_W'(WORD_BITS - 1);

    frame_st_t             state;
    logic [CNT_W-1:0]      cnt;
    logic                  sck_q;
    logic                  sck_rise;
    logic                  dir_q;
    logic                  sel_q;
    logic [WORD_BITS-1:0]  sh;

    // Remember the previous shift-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_q;
    assign sck_fall = ~sck_s & sck_q;
    assign rd_phase = (state == ST_RBODY);

    // Frame sequencer: header decode, body collection and pulse generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HEAD;
            cnt      <= '0;
            dir_q    <= 1'b0;
            sel_q    <= 1'b0;
            sh       <= '0;
            wr_pulse <= 1'b0;
            wr_rs    <= 1'b0;
            wr_data  <= '0;
            rd_req   <= 1'b0;
            rd_rs    <= 1'b0;
        end else begin
            wr_pulse <= 1'b0;
            rd_req   <= 1'b0;
            if (stb_s) begin
                state <= ST_HEAD;
                cnt   <= '0;
            end else begin
                unique case (state)
                    ST_HEAD: if (sck_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt < POS_SYNC) begin
                            if (!sdi_s) state <= ST_HOLD;
                        end else if (cnt == POS_DIR) begin
                            dir_q <= sdi_s;
                        end else if (cnt == POS_SEL) begin
                            sel_q <= sdi_s;
                        end else if (cnt == POS_LAST) begin
                            cnt <= '0;
                            if (sdi_s) begin
                                state <= ST_HOLD;
                            end else if (dir_q) begin
                                state  <= ST_RBODY;
                                rd_req <= 1'b1;
                                rd_rs  <= sel_q;
                            end else begin
                                state <= ST_WBODY;
                            end
                        end
                    end
                    ST_WBODY: if (sck_rise) begin
                        sh  <= {sdi_s, sh[WORD_BITS-1:1]};
                        cnt <= cnt + 1'b1;
                        if (cnt == BODY_END) begin
                            wr_pulse <= 1'b1;
                            wr_data  <= {sdi_s, sh[WORD_BITS-1:1]};
                            wr_rs    <= sel_q;
                            state    <= ST_HOLD;
                        end
                    end
                    ST_RBODY: if (sck_rise) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == BODY_END) state <= ST_HOLD;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    strobe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_s |=> (state == ST_HEAD && cnt == '0));
    // R3
    abort_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !stb_s) |=> (state == ST_HOLD));
    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
    // R5
    wr_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> ($past(state) == ST_WBODY));
    // R6
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    // R9
    extra_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> (!wr_pulse && !rd_req));

endmodule

// File: rtl/sss_tx.sv
// Module: sss_tx
// Captures the read byte when requested and drives it bit by bit, least
// significant first, on each shift-clock fall of the read body.
// Assumes: load never coincides with drive_en (sck phases span several clocks).
module sss_tx #(
    parameter int WORD_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_idle,
    input  logic                 load,
    input  logic [WORD_BITS-1:0] load_data,
    input  logic                 drive_en,
    output logic                 sdo_out,
    output logic                 sdo_oe
);

    localparam int SEL_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(WORD_BITS - 1);

    logic [WORD_BITS-1:0] byte_q;
    logic [SEL_W-1:0]     idx;
    logic                 all_sent;

    // Capture the read byte, then step through its bits on each fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q   <= '0;
            idx      <= '0;
            all_sent <= 1'b0;
            sdo_out  <= 1'b0;
            sdo_oe   <= 1'b0;
        end else if (frame_idle) begin
            idx      <= '0;
            all_sent <= 1'b0;
            sdo_out  <= 1'b0;
            sdo_oe   <= 1'b0;
        end else begin
            if (load) begin
                byte_q   <= load_data;
                idx      <= '0;
                all_sent <= 1'b0;
            end else if (drive_en && !all_sent) begin
                sdo_out <= byte_q[idx];
                sdo_oe  <= 1'b1;
                if (idx == LAST_SEL) all_sent <= 1'b1;
                else                 idx      <= idx + 1'b1;
            end
        end
    end

    // R2
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_idle |=> (!sdo_oe && !sdo_out));
    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en && !frame_idle) |=> $stable(sdo_out));
    // R8
    oe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> $past(drive_en));

endmodule

// File: rtl/strobed_serial_slave.sv
// Module: strobed_serial_slave (top)
// Two-byte strobed serial slave: synchronizes the link pins, sequences
// header and body, and returns read bytes on the split data pad signals.
// Assumes: sck_in phases last several clk periods; pad tristate lives above.
module strobed_serial_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int SYNC_BITS   = 5,
    parameter int WORD_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb_in,
    input  logic                 sck_in,
    input  logic                 sdi_in,
    output logic                 sdo_out,
    output logic                 sdo_oe,
    output logic                 wr_pulse,
    output logic                 wr_rs,
    output logic [WORD_BITS-1:0] wr_data,
    output logic                 rd_req,
    output logic                 rd_rs,
    input  logic [WORD_BITS-1:0] rd_data
);

    logic [2:0] pins_s;
    logic       stb_s;
    logic       sck_s;
    logic       sdi_s;
    logic       rd_phase;
    logic       sck_fall;

    // Pin order {sdi, sck, stb}; the strobe resets high so no frame opens in reset.
    sss_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (3),
        .RESET_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sdi_in, sck_in, stb_in}),
        .dout  (pins_s)
    );

    assign stb_s = pins_s[0];
    assign sck_s = pins_s[1];
    assign sdi_s = pins_s[2];

    sss_frame #(
        .SYNC_BITS (SYNC_BITS),
        .WORD_BITS (WORD_BITS)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_s    (stb_s),
        .sck_s    (sck_s),
        .sdi_s    (sdi_s),
        .wr_pulse (wr_pulse),
        .wr_rs    (wr_rs),
        .wr_data  (wr_data),
        .rd_req   (rd_req),
        .rd_rs    (rd_rs),
        .rd_phase (rd_phase),
        .sck_fall (sck_fall)
    );

    sss_tx #(
        .WORD_BITS (WORD_BITS)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_idle (stb_s),
        .load       (rd_req),
        .load_data  (rd_data),
        .drive_en   (rd_phase & sck_fall),
        .sdo_out    (sdo_out),
        .sdo_oe     (sdo_oe)
    );

    // R4
    no_dual_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && rd_req));

endmodule

// File: tb/strobed_serial_slave_bench.sv
module strobed_serial_slave_bench;

    localparam int SYNC = 3;
    localparam int HALF = 40;
    localparam int GAP  = 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stb_in = 1'b1;
    logic       sck_in = 1'b1;
    logic       sdi_in = 1'b0;
    logic       sdo_out, sdo_oe, wr_pulse, wr_rs, rd_req, rd_rs;
    logic [7:0] wr_data;
    logic [7:0] rd_data = 8'h00;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    bit started = 0;

    always #2.5 clk = ~clk;

    strobed_serial_slave #(.SYNC_STAGES(SYNC), .SYNC_BITS(5), .WORD_BITS(8)) u_strobed_serial_slave (
        .clk(clk), .rst_n(rst_n), .stb_in(stb_in), .sck_in(sck_in), .sdi_in(sdi_in),
        .sdo_out(sdo_out), .sdo_oe(sdo_oe), .wr_pulse(wr_pulse), .wr_rs(wr_rs),
        .wr_data(wr_data), .rd_req(rd_req), .rd_rs(rd_rs), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit q_stb[$], q_sck[$], q_sdi[$];
    int nb, fcnt;
    bit m_abort, m_rw, m_rs;
    logic [7:0] m_wbuf, m_rbyte, m_wr_data;
    bit m_wr_pulse, m_wr_rs, m_rd_req, m_rd_rs, m_sdo, m_oe;

    always @(posedge clk) begin
        bit s, now, prev, d, rise, fall, cap;
        started = 1;
        if (!rst_n) begin
            q_stb = {}; q_sck = {}; q_sdi = {};
            for (int i = 0; i <= SYNC; i++) begin
                q_stb.push_back(1'b1); q_sck.push_back(1'b0); q_sdi.push_back(1'b0);
            end
            nb = 0; fcnt = 0; m_abort = 0; m_rw = 0; m_rs = 0;
            m_wbuf = 0; m_rbyte = 0; m_wr_data = 0;
            m_wr_pulse = 0; m_wr_rs = 0; m_rd_req = 0; m_rd_rs = 0; m_sdo = 0; m_oe = 0;
        end else begin
            q_stb.push_back(stb_in); q_sck.push_back(sck_in); q_sdi.push_back(sdi_in);
            s = q_stb[1]; now = q_sck[1]; prev = q_sck[0]; d = q_sdi[1];
            void'(q_stb.pop_front()); void'(q_sck.pop_front()); void'(q_sdi.pop_front());
            rise = now && !prev;
            fall = !now && prev;
            cap = m_rd_req;
            m_wr_pulse = 0; m_rd_req = 0;
            if (s) begin
                nb = 0; fcnt = 0; m_abort = 0; m_oe = 0; m_sdo = 0;
            end else if (!m_abort) begin
                if (cap) m_rbyte = rd_data;
                if (rise) begin
                    if (nb < 5) begin
                        if (!d) m_abort = 1;
                    end else if (nb == 5) m_rw = d;
                    else if (nb == 6) m_rs = d;
                    else if (nb == 7) begin
                        if (d) m_abort = 1;
                        else if (m_rw) begin m_rd_req = 1; m_rd_rs = m_rs; end
                    end else if (nb < 16 && !m_rw) begin
                        m_wbuf[nb-8] = d;
                        if (nb == 15) begin m_wr_pulse = 1; m_wr_data = m_wbuf; m_wr_rs = m_rs; end
                    end
                    nb++;
                end
                if (fall && m_rw && nb >= 8 && nb < 16 && fcnt < 8) begin
                    m_sdo = m_rbyte[fcnt]; m_oe = 1; fcnt++;
                end
            end
        end
    end

    // Per-frame observations taken at the ports.
    int f_wr, f_rd;
    bit f_oe;

    always @(negedge clk) begin
        if (started) begin
            chk(wr_pulse == m_wr_pulse, "R5", "wr_pulse", wr_pulse, m_wr_pulse);
            chk(wr_data == m_wr_data && wr_rs == m_wr_rs, "R5", "wr_data/wr_rs",
                {wr_rs, wr_data}, {m_wr_rs, m_wr_data});
            chk(rd_req == m_rd_req && rd_rs == m_rd_rs, "R6", "rd_req/rd_rs",
                {rd_req, rd_rs}, {m_rd_req, m_rd_rs});
            chk(sdo_oe == m_oe && sdo_out == m_sdo, "R7", "sdo_oe/sdo_out",
                {sdo_oe, sdo_out}, {m_oe, m_sdo});
            if (wr_pulse) f_wr++;
            if (rd_req) f_rd++;
            if (sdo_oe) f_oe = 1;
        end
    end

    // ---------------- host driver ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives one frame; cut = total bit count after which the strobe rises early (-1 = none).
    task automatic run_frame(input logic [7:0] head, input logic [7:0] body, input int nbody,
                             input int cut, input bit scramble, output logic [7:0] rx);
        int sent = 0;
        bit live = 1;
        rx = 8'h00;
        f_wr = 0; f_rd = 0; f_oe = 0;
        stb_in = 1'b0;
        wait_clk(20);
        for (int i = 0; i < 8; i++) begin
            if (sent == cut) live = 0;
            if (live) begin
                sck_in = 1'b0; sdi_in = head[i]; wait_clk(HALF);
                sck_in = 1'b1; wait_clk(HALF); sent++;
            end
        end
        if (live) wait_clk(GAP);
        for (int i = 0; i < nbody; i++) begin
            if (sent == cut) live = 0;
            if (live) begin
                sck_in = 1'b0; sdi_in = body[i % 8]; wait_clk(HALF);
                if (i < 8) rx[i] = sdo_out;
                sck_in = 1'b1;
                if (i == 0 && scramble) rd_data = ~rd_data;
                wait_clk(HALF); sent++;
            end
        end
        stb_in = 1'b1;
        wait_clk(40);
    endtask

    logic [7:0] rx;

    initial begin
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(2);
        // R1: reset state
        chk(sdo_oe == 0 && sdo_out == 0 && wr_pulse == 0 && rd_req == 0, "R1", "ctrl outputs",
            {sdo_oe, sdo_out, wr_pulse, rd_req}, 0);
        chk(wr_data == 0 && wr_rs == 0 && rd_rs == 0, "R1", "held outputs", {wr_rs, rd_rs, wr_data}, 0);
        wait_clk(50);

        // R5 R4 R8: instruction write 0xA5 (header bit5=0, bit6=0)
        run_frame(8'h1F, 8'hA5, 8, -1, 0, rx);
        chk(f_wr == 1, "R5", "write pulse count", f_wr, 1);
        chk(wr_data == 8'hA5 && wr_rs == 0, "R4", "write byte/rs", {wr_rs, wr_data}, 8'hA5);
        chk(f_oe == 0, "R8", "oe during write", f_oe, 0);

        // R4: data write, rs=1, LSB-first boundaries
        run_frame(8'h5F, 8'h01, 8, -1, 0, rx);
        chk(wr_data == 8'h01 && wr_rs == 1, "R4", "data write 01", {wr_rs, wr_data}, 9'h101);
        run_frame(8'h5F, 8'h80, 8, -1, 0, rx);
        chk(wr_data == 8'h80 && f_wr == 1, "R4", "data write 80", wr_data, 8'h80);

        // R6 R7: instruction read, rd_data changes after capture
        rd_data = 8'h96;
        run_frame(8'h3F, 8'h00, 8, -1, 1, rx);
        chk(f_rd == 1 && rd_rs == 0, "R6", "read request/rs", {f_rd, rd_rs}, 2);
        chk(rx == 8'h96, "R7", "read byte held", rx, 8'h96);
        chk(f_wr == 0, "R6", "no write in read", f_wr, 0);
        chk(sdo_oe == 0, "R2", "oe released after strobe", sdo_oe, 0);

        // R6 R7: data read rs=1
        rd_data = 8'h5A;
        run_frame(8'h7F, 8'h00, 8, -1, 0, rx);
        chk(f_rd == 1 && rd_rs == 1, "R6", "data read rs", {f_rd, rd_rs}, 3);
        chk(rx == 8'h5A, "R7", "data read byte", rx, 8'h5A);

        // R3: bad sync bit, bad closing bit
        run_frame(8'h1E, 8'hFF, 8, -1, 0, rx);
        chk(f_wr == 0 && f_rd == 0 && wr_data == 8'h80, "R3", "sync bit0 zero", {f_wr, f_rd}, 0);
        run_frame(8'h9F, 8'hFF, 8, -1, 0, rx);
        chk(f_wr == 0 && f_rd == 0, "R3", "closing bit one", {f_wr, f_rd}, 0);
        run_frame(8'hAF, 8'hFF, 8, -1, 0, rx);
        chk(f_wr == 0 && f_rd == 0 && f_oe == 0, "R3", "sync bit4 zero read", {f_wr, f_rd, f_oe}, 0);

        // R2: strobe rises mid body, then mid header; next frame works
        run_frame(8'h1F, 8'h3C, 8, 12, 0, rx);
        chk(f_wr == 0 && wr_data == 8'h80, "R2", "cut body no pulse", f_wr, 0);
        run_frame(8'h1F, 8'h3C, 8, 3, 0, rx);
        chk(f_wr == 0, "R2", "cut header no pulse", f_wr, 0);
        run_frame(8'h1F, 8'h3C, 8, -1, 0, rx);
        chk(f_wr == 1 && wr_data == 8'h3C, "R2", "fresh frame after cut", wr_data, 8'h3C);

        // R9: extra clock bits
        run_frame(8'h1F, 8'hC3, 12, -1, 0, rx);
        chk(f_wr == 1 && wr_data == 8'hC3, "R9", "extra bits write", {f_wr, wr_data}, 9'h1C3);
        rd_data = 8'h81;
        run_frame(8'h3F, 8'h00, 12, -1, 0, rx);
        chk(rx == 8'h81 && f_rd == 1, "R9", "extra bits read byte", rx, 8'h81);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule